// File: doc/BRIEF.md
# Repetitive-Sweep Successive Approximation Digitizer

This controller digitizes a repeating analog waveform with one external latching comparator and one external reference DAC. It keeps one code per time point of the record. That code is the result so far, and it is also the reference that the DAC presents to the comparator the next time the signal passes that point. Each trigger starts one sweep over every point of the record at the fixed rate set by the sample-enable ticks. At each point the controller puts the stored code on the DAC and fires the comparator latch, which acts as the sample-and-hold. On the following tick it reads the comparator's decision and writes the code back, moved up or down by the step size of that sweep.

The step is a quarter of full range on the first sweep and halves on each sweep after it. The last sweep only moves a code down by one, and only when the input was below it. An N-bit result therefore needs exactly N triggered sweeps, and each extra bit of resolution costs one more repetition of the signal. After the last sweep the block raises `done_o` and serves reads of the record through a valid/ready request port and a valid/ready response port. A start pulse clears the record to mid-scale and begins a new conversion.

Readout back-pressure works as follows:
- A request is taken only in a cycle where `rd_req_valid_i` and `rd_req_ready_o` are both high.
- `rd_req_ready_o` stays low until `done_o` is high, and it also stays low while a response is still waiting.
- A response stays valid with unchanged data until `rd_resp_ready_i` is high at a clock edge.

Top module: `rsad_top`

## Requirements
- R1: After reset or a start pulse, `done_o` and `latch_o` are low, and every point's reference on the first sweep is the mid-scale code 2^(RES_W-1) (128 for 8 bits).
- R2: Each accepted trigger gives exactly POINTS cycles of `latch_o` high. Each one falls in the clock after a sample-enable tick, on consecutive ticks, for points 0 to POINTS-1 in ascending order.
- R3: In every cycle in which `latch_o` is high, `dac_code_o` shows the stored code of the point being sampled.
- R4: The comparator bit for a point is read at the sample-enable tick that follows that point's latch cycle. A value of 1 means the input is at or above the reference, and the step is added. A value of 0 means the input is below it, and the step is subtracted.
- R5: On sweep k (counting from 0) with k at most RES_W-2, the step is 2^(RES_W-2-k), giving 64, 32 and so on down to 1 for 8 bits. Sweep RES_W-1 subtracts 1 when the bit is 0 and keeps the code when it is 1. Results are clamped to the range 0 to 2^RES_W-1.
- R6: The code written back for a point during one sweep is the DAC reference for that same point on the next sweep.
- R7: A trigger that arrives while a sweep is running, or after `done_o` is high, is ignored and produces no latch activity.
- R8: `done_o` rises after the last write-back of sweep RES_W-1, so a conversion takes exactly RES_W sweeps. With an ideal comparator, each final code equals the input level at its point.
- R9: `rd_req_ready_o` is high only while `done_o` is high and no response is pending. The response appears one clock after the request is accepted, and it holds its data while `rd_resp_ready_i` is low.
- R10: A start pulse clears `done_o`, resets the sweep count, drops any pending response and returns every code to mid-scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears the record to mid-scale and restarts the conversion |
| trig_i | input | 1 | Trigger; starts one sweep when the block is idle |
| smp_en_i | input | 1 | Sample-enable tick that sets the fixed sample rate |
| cmp_i | input | 1 | Comparator decision: 1 means input at or above the reference |
| dac_code_o | output | RES_W | Reference code for the DAC |
| latch_o | output | 1 | Comparator latch strobe (sample instant) |
| done_o | output | 1 | All sweeps finished; record readable |
| rd_req_valid_i | input | 1 | Read request valid |
| rd_req_addr_i | input | AW | Point index to read |
| rd_req_ready_o | output | 1 | Read request accepted |
| rd_resp_valid_o | output | 1 | Read response valid |
| rd_resp_data_o | output | RES_W | Code of the requested point |
| rd_resp_ready_i | input | 1 | Consumer accepts the response |

## Verification
`dac_code_o` and `latch_o` change in the clock after the sample-enable tick that issues a point. The bench therefore checks both on the falling edge of each latch cycle, and it answers with a comparator bit that the design reads on the next tick. The bench does not sample `done_o` until a margin of several tick periods has passed after the last latch of a sweep, because the last write-back lands one tick after that latch. A read response is due one clock after the accepting edge, so the bench checks it on the falling edge that follows. It then holds `rd_resp_ready_i` low for two further clocks to confirm that the response is held.

// File: rtl/rsad_pkg.sv
package rsad_pkg;
  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } sweep_phase_e;
endpackage

// File: rtl/rsad_store.sv
module rsad_store #(
  parameter int RES_W  = 8,
  parameter int POINTS = 16,
  localparam int AW = (POINTS > 1) ? $clog2(POINTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init_i,
  input  logic [AW-1:0]    sw_addr_i,
  output logic [RES_W-1:0] sw_code_o,
  input  logic             wb_en_i,
  input  logic [AW-1:0]    wb_addr_i,
  input  logic             cmp_i,
  input  logic [RES_W-1:0] step_i,
  input  logic             last_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [RES_W-1:0] rd_code_o
);
  localparam logic [RES_W-1:0] MID  = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] FULL = {RES_W{1'b1}};

  logic [RES_W-1:0] mem_q [POINTS];
  logic [RES_W-1:0] cur, nxt, amt;
  logic [RES_W:0]   sum, dif;

  assign sw_code_o = mem_q[sw_addr_i];
  assign rd_code_o = mem_q[rd_addr_i];
  assign cur       = mem_q[wb_addr_i];

  // amount to move: final sweep only steps down by one
  always_comb begin
    amt = last_i ? {{(RES_W-1){1'b0}}, 1'b1} : step_i;
    sum = {1'b0, cur} + {1'b0, amt};
    dif = {1'b0, cur} - {1'b0, amt};
    if (cmp_i) begin
      if (last_i)      nxt = cur;
      else if (sum[RES_W]) nxt = FULL;
      else             nxt = sum[RES_W-1:0];
    end else begin
      if (dif[RES_W])  nxt = '0;
      else             nxt = dif[RES_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < POINTS; i++) mem_q[i] <= MID;
    end else if (init_i) begin
      for (int i = 0; i < POINTS; i++) mem_q[i] <= MID;
    end else if (wb_en_i) begin
      mem_q[wb_addr_i] <= nxt;
    end
  end
endmodule

// File: rtl/rsad_seq.sv
module rsad_seq
  import rsad_pkg::*;
#(
  parameter int RES_W  = 8,
  parameter int POINTS = 16,
  localparam int AW = (POINTS > 1) ? $clog2(POINTS) : 1,
  localparam int CW = $clog2(POINTS + 1),
  localparam int SW = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic             smp_en_i,
  output logic [AW-1:0]    sw_addr_o,
  input  logic [RES_W-1:0] sw_code_i,
  output logic             wb_en_o,
  output logic [AW-1:0]    wb_addr_o,
  output logic [RES_W-1:0] step_o,
  output logic             last_o,
  output logic [RES_W-1:0] dac_code_o,
  output logic             latch_o,
  output logic             done_o
);
  sweep_phase_e     phase_q;
  logic [SW-1:0]    sweep_q;
  logic [CW-1:0]    cnt_q;
  logic             pend_q;
  logic [AW-1:0]    pend_addr_q;
  logic [RES_W-1:0] dac_q;
  logic             latch_q;
  logic             running, issue, more;
  int               sh;

  assign running   = (phase_q == PH_RUN);
  assign more      = (cnt_q < CW'(POINTS));
  assign issue     = running && smp_en_i && more;
  assign wb_en_o   = running && smp_en_i && pend_q;
  assign wb_addr_o = pend_addr_q;
  assign sw_addr_o = cnt_q[AW-1:0];
  assign last_o    = (sweep_q == SW'(RES_W - 1));
  assign done_o    = (phase_q == PH_DONE);
  assign dac_code_o = dac_q;
  assign latch_o    = latch_q;

  always_comb begin
    sh = RES_W - 2 - int'(sweep_q);
    if (sh < 0) sh = 0;
    step_o = {{(RES_W-1){1'b0}}, 1'b1} << sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_WAIT;
      sweep_q     <= '0;
      cnt_q       <= '0;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      dac_q       <= '0;
      latch_q     <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_WAIT;
      sweep_q <= '0;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      latch_q <= issue;
      if (issue) dac_q <= sw_code_i;
      case (phase_q)
        PH_WAIT: begin
          if (trig_i) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
          end
        end
        PH_RUN: begin
          if (smp_en_i) begin
            if (more) begin
              cnt_q       <= cnt_q + 1'b1;
              pend_q      <= 1'b1;
              pend_addr_q <= cnt_q[AW-1:0];
            end else begin
              pend_q  <= 1'b0;
              sweep_q <= sweep_q + 1'b1;
              phase_q <= last_o ? PH_DONE : PH_WAIT;
            end
          end
        end
        default: phase_q <= PH_DONE;
      endcase
    end
  end
endmodule

// File: rtl/rsad_rdport.sv
module rsad_rdport #(
  parameter int RES_W  = 8,
  parameter int POINTS = 16,
  localparam int AW = (POINTS > 1) ? $clog2(POINTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             req_valid_i,
  input  logic [AW-1:0]    req_addr_i,
  output logic             req_ready_o,
  output logic [AW-1:0]    rd_addr_o,
  input  logic [RES_W-1:0] rd_code_i,
  output logic             resp_valid_o,
  output logic [RES_W-1:0] resp_data_o,
  input  logic             resp_ready_i
);
  logic             vld_q;
  logic [RES_W-1:0] data_q;

  assign req_ready_o  = done_i && !vld_q;
  assign rd_addr_o    = req_addr_i;
  assign resp_valid_o = vld_q;
  assign resp_data_o  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else if (start_i) begin
      vld_q <= 1'b0;
    end else if (req_valid_i && req_ready_o) begin
      vld_q  <= 1'b1;
      data_q <= rd_code_i;
    end else if (vld_q && resp_ready_i) begin
      vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rsad_top.sv
module rsad_top #(
  parameter int RES_W  = 8,
  parameter int POINTS = 16,
  localparam int AW = (POINTS > 1) ? $clog2(POINTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic             smp_en_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             latch_o,
  output logic             done_o,
  input  logic             rd_req_valid_i,
  input  logic [AW-1:0]    rd_req_addr_i,
  output logic             rd_req_ready_o,
  output logic             rd_resp_valid_o,
  output logic [RES_W-1:0] rd_resp_data_o,
  input  logic             rd_resp_ready_i
);
  logic [AW-1:0]    sw_addr, wb_addr, rd_addr;
  logic [RES_W-1:0] sw_code, step, rd_code;
  logic             wb_en, last;

  rsad_seq #(.RES_W(RES_W), .POINTS(POINTS)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(trig_i),
    .smp_en_i(smp_en_i), .sw_addr_o(sw_addr), .sw_code_i(sw_code),
    .wb_en_o(wb_en), .wb_addr_o(wb_addr), .step_o(step), .last_o(last),
    .dac_code_o(dac_code_o), .latch_o(latch_o), .done_o(done_o)
  );

  rsad_store #(.RES_W(RES_W), .POINTS(POINTS)) store_i (
    .clk(clk), .rst_n(rst_n), .init_i(start_i),
    .sw_addr_i(sw_addr), .sw_code_o(sw_code),
    .wb_en_i(wb_en), .wb_addr_i(wb_addr), .cmp_i(cmp_i),
    .step_i(step), .last_i(last),
    .rd_addr_i(rd_addr), .rd_code_o(rd_code)
  );

  rsad_rdport #(.RES_W(RES_W), .POINTS(POINTS)) rd_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_i(done_o),
    .req_valid_i(rd_req_valid_i), .req_addr_i(rd_req_addr_i),
    .req_ready_o(rd_req_ready_o), .rd_addr_o(rd_addr), .rd_code_i(rd_code),
    .resp_valid_o(rd_resp_valid_o), .resp_data_o(rd_resp_data_o),
    .resp_ready_i(rd_resp_ready_i)
  );
endmodule

// File: rtl/rsad_chk.sv
module rsad_chk #(
  parameter int RES_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             smp_en_i,
  input logic             latch_o,
  input logic             done_o,
  input logic             rd_req_ready_o,
  input logic             rd_resp_valid_o,
  input logic [RES_W-1:0] rd_resp_data_o,
  input logic             rd_resp_ready_i
);
  // R2
  latch_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_o |-> $past(smp_en_i));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

  // R8
  no_latch_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !latch_o);

  // R9
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid_o && !rd_resp_ready_i && !start_i |=>
      rd_resp_valid_o && $stable(rd_resp_data_o));

  // R9
  resp_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid_o |-> done_o && !rd_req_ready_o);

  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o && !latch_o && !rd_resp_valid_o);
endmodule

bind rsad_top rsad_chk #(.RES_W(RES_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_en_i(smp_en_i),
  .latch_o(latch_o), .done_o(done_o), .rd_req_ready_o(rd_req_ready_o),
  .rd_resp_valid_o(rd_resp_valid_o), .rd_resp_data_o(rd_resp_data_o),
  .rd_resp_ready_i(rd_resp_ready_i)
);

// File: tb/rsad_top_tb_top.sv
module rsad_top_tb_top;
  localparam int RW = 8;
  localparam int NP = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start_i, trig_i, smp_en_i, cmp_i;
  logic [RW-1:0] dac_code_o, rd_resp_data_o;
  logic latch_o, done_o, rd_req_valid_i, rd_req_ready_o, rd_resp_valid_o, rd_resp_ready_i;
  logic [AW-1:0] rd_req_addr_i;

  rsad_top #(.RES_W(RW), .POINTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(trig_i),
    .smp_en_i(smp_en_i), .cmp_i(cmp_i), .dac_code_o(dac_code_o),
    .latch_o(latch_o), .done_o(done_o), .rd_req_valid_i(rd_req_valid_i),
    .rd_req_addr_i(rd_req_addr_i), .rd_req_ready_o(rd_req_ready_o),
    .rd_resp_valid_o(rd_resp_valid_o), .rd_resp_data_o(rd_resp_data_o),
    .rd_resp_ready_i(rd_resp_ready_i)
  );

  int total = 0, bad = 0;
  int vin [NP];
  int exp_ref [NP];
  int lat_total = 0;
  int base = 0;
  int cur_sweep = 0;
  int en_mode = 0;
  int div = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  // sample-enable pattern: every (en_mode+1) cycles
  initial smp_en_i = 1'b0;
  always @(negedge clk) begin
    div = div + 1;
    smp_en_i <= ((div % (en_mode + 1)) == 0);
  end

  // comparator model and reference expectation
  initial cmp_i = 1'b0;
  always @(negedge clk) begin
    if (start_i) for (int p = 0; p < NP; p++) exp_ref[p] = 1 << (RW - 1);
    if (latch_o) begin
      int idx;
      bit c;
      idx = lat_total - base;
      if (idx < NP) begin
        if (cur_sweep == 0)
          chk(dac_code_o == exp_ref[idx], "R1 R3 mid-scale reference", dac_code_o, exp_ref[idx]);
        else
          chk(dac_code_o == exp_ref[idx], "R3 R4 R5 R6 reference", dac_code_o, exp_ref[idx]);
        c = (vin[idx] >= int'(dac_code_o));
        cmp_i = c;
        if (cur_sweep < RW - 1) begin
          if (c) exp_ref[idx] = exp_ref[idx] + (1 << (RW - 2 - cur_sweep));
          else   exp_ref[idx] = exp_ref[idx] - (1 << (RW - 2 - cur_sweep));
          if (exp_ref[idx] > (1 << RW) - 1) exp_ref[idx] = (1 << RW) - 1;
          if (exp_ref[idx] < 0) exp_ref[idx] = 0;
        end else if (!c && exp_ref[idx] > 0) begin
          exp_ref[idx] = exp_ref[idx] - 1;
        end
      end else begin
        chk(1'b0, "R2 R7 extra latch", idx + 1, NP);
      end
      lat_total = lat_total + 1;
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog R2 sweep progress act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; trig_i = 1'b0;
    rd_req_valid_i = 1'b0; rd_req_addr_i = '0; rd_resp_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done_o == 1'b0, "R1 done after reset", done_o, 0);
    chk(latch_o == 1'b0, "R1 latch after reset", latch_o, 0);
    chk(rd_req_ready_o == 1'b0, "R9 ready before done", rd_req_ready_o, 0);

    for (int rec = 0; rec < 32; rec++) begin
      en_mode = rec % 3;
      for (int p = 0; p < NP; p++) vin[p] = ((rec * NP + p) * 37 + 11) % 256;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      chk(done_o == 1'b0, "R10 done cleared by start", done_o, 0);
      chk(rd_resp_valid_o == 1'b0, "R10 response dropped", rd_resp_valid_o, 0);
      // request before done must not be taken
      rd_req_valid_i = 1'b1;
      rd_req_addr_i = '0;
      repeat (2) @(negedge clk);
      rd_req_valid_i = 1'b0;
      chk(rd_resp_valid_o == 1'b0, "R9 request refused before done", rd_resp_valid_o, 0);

      for (int s = 0; s < RW; s++) begin
        cur_sweep = s;
        base = lat_total;
        trig_i = 1'b1;
        @(negedge clk);
        trig_i = 1'b0;
        while (lat_total - base < 2) @(negedge clk);
        trig_i = 1'b1;   // R7: trigger mid-sweep, ignored
        @(negedge clk);
        trig_i = 1'b0;
        while (lat_total - base < NP) @(negedge clk);
        repeat (10) @(negedge clk);
        chk(lat_total - base == NP, "R2 latch count per sweep", lat_total - base, NP);
        chk(done_o == (s == RW - 1), "R8 done after last sweep", done_o, (s == RW - 1));
      end

      // R7: trigger after done is ignored
      base = lat_total;
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      repeat (20) @(negedge clk);
      chk(lat_total == base, "R7 trigger after done ignored", lat_total - base, 0);
      chk(done_o == 1'b1, "R7 done held", done_o, 1);

      for (int p = 0; p < NP; p++) begin
        rd_req_valid_i = 1'b1;
        rd_req_addr_i = AW'(p);
        @(negedge clk);
        rd_req_valid_i = 1'b0;
        chk(rd_resp_valid_o == 1'b1, "R9 response one clock after accept", rd_resp_valid_o, 1);
        chk(int'(rd_resp_data_o) == vin[p], "R8 final code", rd_resp_data_o, vin[p]);
        if ((p % 2) == 0) begin
          repeat (2) @(negedge clk);
          chk(rd_resp_valid_o == 1'b1, "R9 response held", rd_resp_valid_o, 1);
          chk(int'(rd_resp_data_o) == vin[p], "R9 data held", rd_resp_data_o, vin[p]);
        end
        rd_resp_ready_i = 1'b1;
        @(negedge clk);
        rd_resp_ready_i = 1'b0;
        chk(rd_resp_valid_o == 1'b0, "R9 response drained", rd_resp_valid_o, 0);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule